// File: doc/BRIEF.md
# Split-Transaction Completion Response Handler

This block sits on the host side of a periodic interrupt transfer to a full- or low-speed device behind a high-speed hub. When a complete-split returns, the schedule logic presents the decoded handshake, the endpoint direction, whether the current micro-frame still has time for another attempt, and the number of bytes received. The block then updates the queue-head state it holds and reports one next action.

The queue-head state consists of a 2-bit error counter, the status bits (active, halted, transaction error, split error), the current offset, the bytes left to transfer, the data toggle and the split byte accumulator. The schedule logic writes the offset, byte count and toggle with a load strobe before it starts a queue. Every later change comes from the responses. Packet serialisation, CRC checking, memory traffic and schedule walking are handled elsewhere.

Response codes on `resp_code`: 0 transaction error, 1 ACK, 2 MDATA, 3 DATA0, 4 DATA1, 5 NAK, 6 ERR, 7 STALL. Action codes on `act_code`: 1 issue another complete split, 2 exit this queue head, 3 return to start split, 4 halt the queue.

Top module: `csplit_resp_handler`

## Requirements
- R1: After reset, the outputs are: act_valid 0, retire 0, illegal 0, error counter 3, active 0, halted 0, both error bits 0, offset 0, bytes left 0, toggle 0, split bytes 0. A load strobe sets offset, bytes left and toggle from the load inputs, sets active to 1, sets the error counter to 3, and clears halted, both error bits and split bytes.
- R2: Each cycle with resp_valid high produces exactly one act_valid pulse with an action code in the next cycle. act_valid is 0 in every cycle that does not follow a response.
- R3: On a transaction error (code 0), the transaction-error bit is set and the error counter decrements, saturating at 0. If the new count is non-zero and time remains, the action is 1.
- R4: On a transaction error, the action is 4 and the queue halts (halted set, active cleared) in two cases: the new count is 0, or no time remains and the endpoint is IN.
- R5: On a transaction error on an OUT endpoint with no time left and a non-zero new count, the action is 3.
- R6: ACK on OUT: let n be the lesser of the maximum packet length and the bytes left. n is added to the offset and subtracted from the bytes left. The toggle flips, the counter reloads to 3, and the action is 2.
- R7: MDATA on IN adds the received bytes to split bytes. The counter is unchanged and the action is 1.
- R8: DATA0 (when toggle is 0) or DATA1 (when toggle is 1) on IN: let t be split bytes plus the received bytes. The lesser of t and the bytes left is added to the offset and subtracted from the bytes left. The toggle flips, split bytes clears, and the action is 2.
- R9: DATA0 or DATA1 whose PID does not match the toggle clears split bytes. Offset, bytes left, toggle and the counter stay unchanged, and the action is 2.
- R10: NAK reloads the counter to 3, does not advance the transfer, and the action is 2.
- R11: ERR sets the split-error bit and decrements the counter, saturating at 0. The transfer does not advance and the action is 2.
- R12: STALL clears active, sets halted, pulses retire, and the action is 4.
- R13: ACK on IN, or MDATA, DATA0 or DATA1 on OUT, sets the sticky illegal output until reset. All queue-head state is left unchanged and the action is 2.
- R14: While halted, a response changes no state and the action is 4. retire pulses for one cycle whenever an advance takes a non-zero bytes-left count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| qh_load | input | 1 | Load a new queue head |
| ld_offset | input | BYTES_W | Offset to load |
| ld_bytes | input | BYTES_W | Bytes to transfer to load |
| ld_toggle | input | 1 | Data toggle to load |
| max_pkt | input | PKT_W | Maximum packet length |
| resp_valid | input | 1 | A decoded response is present |
| resp_code | input | 3 | Response code |
| dir_in | input | 1 | 1 = IN endpoint, 0 = OUT |
| time_left | input | 1 | Micro-frame has time for a retry |
| rx_bytes | input | PKT_W | Bytes received in this response |
| act_valid | output | 1 | Action strobe |
| act_code | output | 3 | Next action |
| retire | output | 1 | Descriptor retire pulse |
| illegal | output | 1 | Sticky illegal-response flag |
| cerr | output | 2 | Error counter |
| st_active | output | 1 | Active status bit |
| st_halted | output | 1 | Halted status bit |
| st_xact_err | output | 1 | Transaction-error status bit |
| st_err | output | 1 | Split-error status bit |
| cur_offset | output | BYTES_W | Current offset |
| bytes_left | output | BYTES_W | Bytes remaining |
| data_toggle | output | 1 | Expected data toggle |
| split_bytes | output | BYTES_W | Accumulated split byte count |

## Verification
The bench drives the error counter down 3 to 2 to 1 to 0 with transaction errors. The last step must halt even though time remains; a design that tests the old count instead of the new one would retry once more. It then runs the counter to 0 with ERR responses, which must not halt, and checks that a further decrement saturates rather than wrapping to 3. A transaction error on OUT with no time left must return to start split, while the same error on IN must halt; a design that mixes up the two directions takes the wrong one of these actions. ACKs and matching DATA responses with a byte count smaller than the maximum packet length must clamp to the bytes left and raise retire exactly once. Random response streams include illegal codes for the direction and responses that arrive while halted; the bench checks that neither changes any queue-head output.

// File: rtl/csplit_resp_handler.sv
module csplit_resp_handler #(
  parameter int BYTES_W  = 15,
  parameter int PKT_W    = 11,
  parameter int CERR_MAX = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               qh_load,
  input  logic [BYTES_W-1:0] ld_offset,
  input  logic [BYTES_W-1:0] ld_bytes,
  input  logic               ld_toggle,
  input  logic [PKT_W-1:0]   max_pkt,
  input  logic               resp_valid,
  input  logic [2:0]         resp_code,
  input  logic               dir_in,
  input  logic               time_left,
  input  logic [PKT_W-1:0]   rx_bytes,
  output logic               act_valid,
  output logic [2:0]         act_code,
  output logic               retire,
  output logic               illegal,
  output logic [1:0]         cerr,
  output logic               st_active,
  output logic               st_halted,
  output logic               st_xact_err,
  output logic               st_err,
  output logic [BYTES_W-1:0] cur_offset,
  output logic [BYTES_W-1:0] bytes_left,
  output logic               data_toggle,
  output logic [BYTES_W-1:0] split_bytes
);

  localparam logic [1:0] CMAX = 2'(CERR_MAX);
  localparam logic [2:0] A_CSPLIT = 3'd1, A_EXIT = 3'd2, A_START = 3'd3, A_HALT = 3'd4;
  localparam logic [2:0] R_XERR = 3'd0, R_ACK = 3'd1, R_MDATA = 3'd2, R_DATA0 = 3'd3,
                         R_DATA1 = 3'd4, R_NAK = 3'd5, R_ERR = 3'd6, R_STALL = 3'd7;

  logic               legal;
  logic [1:0]         cerr_dec;
  logic [BYTES_W-1:0] pkt_ext, rx_ext, rx_total, ack_amt, dat_amt;
  logic               pid_match;

  always_comb begin
    case (resp_code)
      R_ACK:                    legal = !dir_in;
      R_MDATA, R_DATA0, R_DATA1: legal = dir_in;
      default:                  legal = 1'b1;
    endcase
  end

  assign cerr_dec  = (cerr == 2'd0) ? 2'd0 : cerr - 2'd1;
  assign pkt_ext   = BYTES_W'(max_pkt);
  assign rx_ext    = BYTES_W'(rx_bytes);
  assign rx_total  = split_bytes + rx_ext;
  assign ack_amt   = (pkt_ext < bytes_left) ? pkt_ext : bytes_left;
  assign dat_amt   = (rx_total < bytes_left) ? rx_total : bytes_left;
  assign pid_match = (resp_code == R_DATA1) == data_toggle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid   <= 1'b0;
      act_code    <= 3'd0;
      retire      <= 1'b0;
      illegal     <= 1'b0;
      cerr        <= CMAX;
      st_active   <= 1'b0;
      st_halted   <= 1'b0;
      st_xact_err <= 1'b0;
      st_err      <= 1'b0;
      cur_offset  <= '0;
      bytes_left  <= '0;
      data_toggle <= 1'b0;
      split_bytes <= '0;
    end else begin
      act_valid <= 1'b0;
      retire    <= 1'b0;
      if (qh_load) begin
        cur_offset  <= ld_offset;
        bytes_left  <= ld_bytes;
        data_toggle <= ld_toggle;
        cerr        <= CMAX;
        st_active   <= 1'b1;
        st_halted   <= 1'b0;
        st_xact_err <= 1'b0;
        st_err      <= 1'b0;
        split_bytes <= '0;
      end else if (resp_valid) begin
        act_valid <= 1'b1;
        act_code  <= A_EXIT;
        if (st_halted) begin
          act_code <= A_HALT;
        end else if (!legal) begin
          illegal <= 1'b1;
        end else begin
          case (resp_code)
            R_XERR: begin
              st_xact_err <= 1'b1;
              cerr        <= cerr_dec;
              if (cerr_dec == 2'd0 || (!time_left && dir_in)) begin
                act_code  <= A_HALT;
                st_halted <= 1'b1;
                st_active <= 1'b0;
              end else if (!time_left) begin
                act_code <= A_START;
              end else begin
                act_code <= A_CSPLIT;
              end
            end
            R_ACK: begin
              cur_offset  <= cur_offset + ack_amt;
              bytes_left  <= bytes_left - ack_amt;
              data_toggle <= !data_toggle;
              cerr        <= CMAX;
              retire      <= (bytes_left != '0) && (bytes_left == ack_amt);
            end
            R_MDATA: begin
              split_bytes <= rx_total;
              act_code    <= A_CSPLIT;
            end
            R_DATA0, R_DATA1: begin
              split_bytes <= '0;
              if (pid_match) begin
                cur_offset  <= cur_offset + dat_amt;
                bytes_left  <= bytes_left - dat_amt;
                data_toggle <= !data_toggle;
                retire      <= (bytes_left != '0) && (bytes_left == dat_amt);
              end
            end
            R_NAK: cerr <= CMAX;
            R_ERR: begin
              st_err <= 1'b1;
              cerr   <= cerr_dec;
            end
            default: begin
              act_code  <= A_HALT;
              st_active <= 1'b0;
              st_halted <= 1'b1;
              retire    <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  // R2
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !qh_load) |=> act_valid);
  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |=> !act_valid);
  // R10
  nak_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !qh_load && !st_halted && resp_code == R_NAK) |=> (cerr == CMAX));
  // R12
  stall_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !qh_load && !st_halted && resp_code == R_STALL)
      |=> (st_halted && !st_active && retire && act_code == A_HALT));
  // R13
  illegal_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);
  // R14
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_halted && !qh_load) |=> (st_halted && $stable(bytes_left) && $stable(cerr)));

endmodule

// File: tb/test_csplit_resp_handler.sv
module test_csplit_resp_handler;
  localparam int BW = 15;
  localparam int PW = 11;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          qh_load = 1'b0, ld_toggle = 1'b0;
  logic [BW-1:0] ld_offset = '0, ld_bytes = '0;
  logic [PW-1:0] max_pkt = PW'(64), rx_bytes = '0;
  logic          resp_valid = 1'b0, dir_in = 1'b0, time_left = 1'b1;
  logic [2:0]    resp_code = 3'd0;
  logic          act_valid, retire, illegal, st_active, st_halted, st_xact_err, st_err, data_toggle;
  logic [2:0]    act_code;
  logic [1:0]    cerr;
  logic [BW-1:0] cur_offset, bytes_left, split_bytes;

  csplit_resp_handler #(.BYTES_W(BW), .PKT_W(PW), .CERR_MAX(3)) i_csplit_resp_handler (
    .clk(clk), .rst_n(rst_n), .qh_load(qh_load), .ld_offset(ld_offset), .ld_bytes(ld_bytes),
    .ld_toggle(ld_toggle), .max_pkt(max_pkt), .resp_valid(resp_valid), .resp_code(resp_code),
    .dir_in(dir_in), .time_left(time_left), .rx_bytes(rx_bytes), .act_valid(act_valid),
    .act_code(act_code), .retire(retire), .illegal(illegal), .cerr(cerr), .st_active(st_active),
    .st_halted(st_halted), .st_xact_err(st_xact_err), .st_err(st_err), .cur_offset(cur_offset),
    .bytes_left(bytes_left), .data_toggle(data_toggle), .split_bytes(split_bytes));

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  int m_cerr = 3, m_act = 0, m_halt = 0, m_xerr = 0, m_err = 0, m_ill = 0;
  int m_off = 0, m_rem = 0, m_tog = 0, m_sb = 0;

  task automatic chk(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic chk_state(string r);
    chk(r, "cerr", int'(cerr), m_cerr);
    chk(r, "active", int'(st_active), m_act);
    chk(r, "halted", int'(st_halted), m_halt);
    chk(r, "xact_err", int'(st_xact_err), m_xerr);
    chk(r, "err", int'(st_err), m_err);
    chk(r, "illegal", int'(illegal), m_ill);
    chk(r, "offset", int'(cur_offset), m_off);
    chk(r, "bytes_left", int'(bytes_left), m_rem);
    chk(r, "toggle", int'(data_toggle), m_tog);
    chk(r, "split_bytes", int'(split_bytes), m_sb);
  endtask

  function automatic int dec(int v);
    return (v == 0) ? 0 : v - 1;
  endfunction

  function automatic int min2(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic do_load(int off, int rem, int tog);
    qh_load = 1'b1; ld_offset = BW'(off); ld_bytes = BW'(rem); ld_toggle = tog[0];
    @(posedge clk); @(negedge clk);
    qh_load = 1'b0;
    m_off = off; m_rem = rem; m_tog = tog; m_cerr = 3; m_act = 1; m_halt = 0;
    m_xerr = 0; m_err = 0; m_sb = 0;
    chk_state("R1");
  endtask

  task automatic respond(int code, int din, int tl, int rx);
    string tag;
    int e_act, e_ret, amt, tot;
    resp_valid = 1'b1; resp_code = 3'(code); dir_in = din[0]; time_left = tl[0]; rx_bytes = PW'(rx);
    @(posedge clk); @(negedge clk);
    resp_valid = 1'b0;
    e_ret = 0; e_act = 2;
    if (m_halt != 0) begin
      e_act = 4; tag = "R14";
    end else if ((code == 1 && din == 1) || ((code >= 2 && code <= 4) && din == 0)) begin
      m_ill = 1; tag = "R13";
    end else begin
      case (code)
        0: begin
          m_xerr = 1; m_cerr = dec(m_cerr);
          if (m_cerr == 0 || (tl == 0 && din == 1)) begin
            m_halt = 1; m_act = 0; e_act = 4; tag = "R4";
          end else if (tl == 0) begin
            e_act = 3; tag = "R5";
          end else begin
            e_act = 1; tag = "R3";
          end
        end
        1: begin
          amt = min2(int'(max_pkt), m_rem);
          if (m_rem != 0 && m_rem == amt) e_ret = 1;
          m_off += amt; m_rem -= amt; m_tog ^= 1; m_cerr = 3; tag = "R6";
        end
        2: begin
          m_sb += rx; e_act = 1; tag = "R7";
        end
        3, 4: begin
          if (code - 3 == m_tog) begin
            tot = m_sb + rx; amt = min2(tot, m_rem);
            if (m_rem != 0 && m_rem == amt) e_ret = 1;
            m_off += amt; m_rem -= amt; m_tog ^= 1; tag = "R8";
          end else tag = "R9";
          m_sb = 0;
        end
        5: begin
          m_cerr = 3; tag = "R10";
        end
        6: begin
          m_err = 1; m_cerr = dec(m_cerr); tag = "R11";
        end
        default: begin
          m_act = 0; m_halt = 1; e_ret = 1; e_act = 4; tag = "R12";
        end
      endcase
    end
    chk("R2", "act_valid", int'(act_valid), 1);
    chk(tag, "act_code", int'(act_code), e_act);
    chk(tag, "retire", int'(retire), e_ret);
    chk_state(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    m_act = 0;
    chk_state("R1");
    chk("R1", "act_valid", int'(act_valid), 0);
    chk("R1", "retire", int'(retire), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4: 3->2->1 retry, 1->0 halts despite time left
    do_load(0, 100, 0);
    respond(0, 1, 1, 0);
    respond(0, 1, 1, 0);
    respond(0, 1, 1, 0);
    respond(5, 1, 1, 0);
    // R4: IN with no time halts at count 3->2
    do_load(0, 100, 0);
    respond(0, 1, 0, 0);
    // R5: OUT with no time returns to start split
    do_load(0, 100, 0);
    respond(0, 0, 0, 0);
    // R11: ERR saturates, no halt; then transaction error at 0 halts (R4)
    respond(6, 0, 1, 0);
    respond(6, 0, 1, 0);
    respond(6, 0, 1, 0);
    respond(0, 0, 1, 0);
    // R6: ACK clamps to bytes left and retires
    max_pkt = PW'(64);
    do_load(10, 100, 1);
    respond(1, 0, 1, 0);
    respond(1, 0, 1, 0);
    respond(1, 0, 1, 0);
    // R7 R8 R9: MDATA accumulation then DATA
    do_load(0, 50, 0);
    respond(2, 1, 1, 20);
    respond(4, 1, 1, 5);
    respond(2, 1, 1, 20);
    respond(3, 1, 1, 40);
    // R13: illegal on both directions
    respond(1, 1, 1, 0);
    respond(2, 0, 1, 9);
    // R12 then R14
    respond(7, 0, 1, 0);
    respond(1, 0, 1, 0);
    // R2: idle cycle yields no action
    @(negedge clk);
    chk("R2", "idle act_valid", int'(act_valid), 0);

    for (int q = 0; q < 40; q++) begin
      int din;
      din = int'($urandom_range(1));
      max_pkt = PW'($urandom_range(64, 8));
      do_load(int'($urandom_range(500)), int'($urandom_range(300)), int'($urandom_range(1)));
      for (int k = 0; k < 12; k++) begin
        int d;
        d = ($urandom_range(9) == 0) ? 1 - din : din;
        respond(int'($urandom_range(7)), d, ($urandom_range(4) != 0) ? 1 : 0,
                int'($urandom_range(70)));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule